// File: doc/BRIEF.md
# Instruction trace exception unit

This unit sits beside the execute stage of a processor and turns the two trace-enable bits of the machine state word into trace exceptions. Each cycle it may be handed one instruction, with a 4-bit class code and the current machine state word. When the instruction completes and tracing applies to it, the unit arms a pending trace. The trace is not taken on the instruction that armed it. It is taken on the next valid instruction, which is dropped and replaced by a redirect to the trace vector. The unit also supplies the status word that is saved on entry.

An asynchronous interrupt request is modelled only as a priority input. An armed trace always wins over it. In the cycle after any exception is taken, the unit runs one save cycle. In that cycle it supplies the entry value of the machine state word and clears the pending trace, and the incoming instruction is not accepted.

Bit numbers in this brief are big-endian: bit 0 is the most significant of 64, so big-endian bit k is vector index 63-k.

Top module: `trc_unit`

## Requirements
- R1: After reset no trace is pending and no save cycle is active, so the first valid instruction completes (`insn_done`=1, `trace_taken`=0).
- R2: With single-step (state bit 53) set, a completed instruction arms a trace. The next valid instruction then gives `trace_taken`=1, `redirect_valid`=1, `redirect_addr`=0xD00 and `insn_done`=0.
- R3: With branch-trace (state bit 54) set, a completed branch arms a trace whether or not the branch was taken, even if single-step is clear. The branch classes are 4 (unconditional), 5 (conditional) and 6 (conditional to register). With both bits clear nothing arms, and with only branch-trace set a non-branch does not arm.
- R4: Return-from-interrupt (class 7) never arms a trace, whatever the enable bits.
- R5: A pending trace is held across cycles that have no valid instruction.
- R6: When a trace is pending and an interrupt is requested on the same valid instruction, the trace is taken and `irq_taken` stays 0.
- R7: Every trace sets status bit 33 (index 30). Bit 35 (index 28) is also set if the traced instruction was a load or counts as one: class 2 (load), 8, 9, 10, 11 or 12 (icbi, icbt, dcbt, dcbst, dcbf). Bit 36 (index 27) is set instead if it was a store or counts as one: class 3 (store), 13 or 14 (dcbz, dcbtst). No other bit is set. Class 1 is a plain ALU operation and class 0 means none.
- R8: The cycle after any trace or interrupt is taken is a save cycle. In it `msr_wr`=1, and `msr_new` equals `msr_in` with bits 48, 49, 53, 54, 58, 59 and 62 cleared and bits 0 and 63 set. The pending trace is cleared, and the incoming instruction is ignored: it neither completes nor arms.
- R9: With no trace pending, a valid instruction that arrives while an interrupt is requested gives `irq_taken`=1 and `insn_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn_class | input | 4 | Class code of the presented instruction |
| msr_in | input | 64 | Current machine state word |
| irq_pending | input | 1 | An asynchronous interrupt is requested |
| insn_done | output | 1 | The presented instruction completes |
| trace_taken | output | 1 | A trace exception replaces the presented instruction |
| irq_taken | output | 1 | An interrupt replaces the presented instruction |
| redirect_valid | output | 1 | Fetch redirect to the trace vector |
| redirect_addr | output | 64 | Redirect target |
| status_word | output | 64 | Status bits to save when a trace is taken |
| msr_wr | output | 1 | Save cycle: write `msr_new` |
| msr_new | output | 64 | Machine state word on exception entry |

## Verification
The assertions assume that `insn_class` and `msr_in` are meaningful only while `insn_valid` or the save cycle is active. They also assume that an interrupt request is honoured only together with a valid instruction. The stimulus drives every input on the falling clock edge and holds it for a full cycle. Each table entry is followed by a trace-free instruction, and then by a save cycle or an idle cycle, so every entry starts with no trace pending.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int unsigned XLEN = 64;
    localparam int unsigned CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE   = 4'd0,
        CLS_ALU    = 4'd1,
        CLS_LOAD   = 4'd2,
        CLS_STORE  = 4'd3,
        CLS_BR     = 4'd4,
        CLS_BCOND  = 4'd5,
        CLS_BCREG  = 4'd6,
        CLS_RFI    = 4'd7,
        CLS_ICINV  = 4'd8,
        CLS_ICTCH  = 4'd9,
        CLS_DCTCH  = 4'd10,
        CLS_DCSTO  = 4'd11,
        CLS_DCFLS  = 4'd12,
        CLS_DCZERO = 4'd13,
        CLS_DCTST  = 4'd14,
        CLS_RSVD   = 4'd15
    } insn_class_e;

    typedef struct packed {
        logic is_branch;
        logic is_rfi;
        logic ld_like;
        logic st_like;
    } class_info_t;

    // big-endian bit numbers of the machine state and status words
    localparam int unsigned BE_SF   = 0;
    localparam int unsigned BE_EE   = 48;
    localparam int unsigned BE_PR   = 49;
    localparam int unsigned BE_STEP = 53;
    localparam int unsigned BE_BRTR = 54;
    localparam int unsigned BE_IR   = 58;
    localparam int unsigned BE_DR   = 59;
    localparam int unsigned BE_RI   = 62;
    localparam int unsigned BE_LE   = 63;
    localparam int unsigned BE_TRC  = 33;
    localparam int unsigned BE_LD   = 35;
    localparam int unsigned BE_ST   = 36;

    function automatic int unsigned be_idx(input int unsigned k);
        return XLEN - 1 - k;
    endfunction

endpackage

// File: rtl/trc_classify.sv
module trc_classify
    import trc_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output class_info_t      info
);
    insn_class_e c;

    always_comb begin
        c = insn_class_e'(cls);
        info = '0;
        unique case (c)
            CLS_BR, CLS_BCOND, CLS_BCREG: info.is_branch = 1'b1;
            CLS_RFI:                      info.is_rfi    = 1'b1;
            CLS_LOAD, CLS_ICINV, CLS_ICTCH,
            CLS_DCTCH, CLS_DCSTO, CLS_DCFLS: info.ld_like = 1'b1;
            CLS_STORE, CLS_DCZERO, CLS_DCTST: info.st_like = 1'b1;
            default: info = '0;
        endcase
    end
endmodule

// File: rtl/trc_status.sv
module trc_status
    import trc_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  class_info_t prev,
    output logic [W-1:0] word
);
    localparam int unsigned I_TRC = W - 1 - BE_TRC;
    localparam int unsigned I_LD  = W - 1 - BE_LD;
    localparam int unsigned I_ST  = W - 1 - BE_ST;

    always_comb begin
        word = '0;
        word[I_TRC] = 1'b1;
        if (prev.ld_like)
            word[I_LD] = 1'b1;
        else if (prev.st_like)
            word[I_ST] = 1'b1;
    end
endmodule

// File: rtl/trc_msr_entry.sv
module trc_msr_entry
    import trc_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam int unsigned NCLR = 7;
    localparam int unsigned CLR_BE [NCLR] = '{BE_EE, BE_PR, BE_STEP, BE_BRTR, BE_IR, BE_DR, BE_RI};

    logic [W-1:0] clr_mask;
    logic [W-1:0] set_mask;

    generate
        for (genvar g = 0; g < W; g++) begin : g_mask
            localparam int unsigned BE = W - 1 - g;
            always_comb begin
                clr_mask[g] = 1'b0;
                for (int j = 0; j < NCLR; j++)
                    if (CLR_BE[j] == BE) clr_mask[g] = 1'b1;
                set_mask[g] = (BE == BE_SF) || (BE == BE_LE);
            end
        end
    endgenerate

    assign nxt = (cur & ~clr_mask) | set_mask;
endmodule

// File: rtl/trc_unit.sv
module trc_unit
    import trc_pkg::*;
#(
    parameter int unsigned W          = XLEN,
    parameter logic [W-1:0] TRACE_VEC = 'h0D00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_valid,
    input  logic [CLS_W-1:0] insn_class,
    input  logic [W-1:0]     msr_in,
    input  logic             irq_pending,
    output logic             insn_done,
    output logic             trace_taken,
    output logic             irq_taken,
    output logic             redirect_valid,
    output logic [W-1:0]     redirect_addr,
    output logic [W-1:0]     status_word,
    output logic             msr_wr,
    output logic [W-1:0]     msr_new
);
    localparam int unsigned I_STEP = W - 1 - BE_STEP;
    localparam int unsigned I_BRTR = W - 1 - BE_BRTR;

    logic        pend_q, save_q;
    class_info_t prev_q;
    class_info_t cur_info;
    logic        arm;

    trc_classify u_cls (.cls(insn_class), .info(cur_info));
    trc_status #(.W(W)) u_stat (.prev(prev_q), .word(status_word));
    trc_msr_entry #(.W(W)) u_msr (.cur(msr_in), .nxt(msr_new));

    // priority: save cycle, armed trace, interrupt, normal completion
    always_comb begin
        msr_wr      = save_q;
        trace_taken = !save_q && insn_valid && pend_q;
        irq_taken   = !save_q && insn_valid && !pend_q && irq_pending;
        insn_done   = !save_q && insn_valid && !pend_q && !irq_pending;
        arm = insn_done && !cur_info.is_rfi &&
              (msr_in[I_STEP] || (msr_in[I_BRTR] && cur_info.is_branch));
    end

    assign redirect_valid = trace_taken;
    assign redirect_addr  = trace_taken ? TRACE_VEC : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            save_q <= 1'b0;
            prev_q <= '0;
        end else begin
            save_q <= trace_taken || irq_taken;
            if (save_q)
                pend_q <= 1'b0;
            else if (trace_taken)
                pend_q <= 1'b0;
            else if (insn_done)
                pend_q <= arm;
            if (insn_done)
                prev_q <= cur_info;
        end
    end

    p_trace_prio_r6: assert property (@(posedge clk) disable iff (rst)
        trace_taken |-> !irq_taken);
    p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trace_taken, irq_taken, insn_done, msr_wr}));
    p_vector_r2: assert property (@(posedge clk) disable iff (rst)
        trace_taken |-> (redirect_valid && redirect_addr == TRACE_VEC));
    p_save_after_r8: assert property (@(posedge clk) disable iff (rst)
        (trace_taken || irq_taken) |=> msr_wr);
    p_save_clears_r8: assert property (@(posedge clk) disable iff (rst)
        msr_wr |=> !pend_q);
    p_rfi_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (insn_done && insn_class == CLS_RFI) |=> !pend_q);
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!insn_valid && !msr_wr) |=> $stable(pend_q));
    p_status_r7: assert property (@(posedge clk) disable iff (rst)
        trace_taken |-> $countones(status_word) inside {1, 2});
endmodule

// File: tb/test_trc_unit.sv
module test_trc_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;
    // {step, brtr, class[3:0], expect_trace, kind[1:0]}  kind: 0 plain, 1 load-like, 2 store-like
    localparam logic [8:0] VEC [NVEC] = '{
        {1'b1,1'b0,4'd1, 1'b1,2'd0},
        {1'b1,1'b0,4'd2, 1'b1,2'd1},
        {1'b1,1'b0,4'd3, 1'b1,2'd2},
        {1'b1,1'b0,4'd8, 1'b1,2'd1},
        {1'b1,1'b0,4'd9, 1'b1,2'd1},
        {1'b1,1'b0,4'd10,1'b1,2'd1},
        {1'b1,1'b0,4'd11,1'b1,2'd1},
        {1'b1,1'b0,4'd12,1'b1,2'd1},
        {1'b1,1'b0,4'd13,1'b1,2'd2},
        {1'b1,1'b0,4'd14,1'b1,2'd2},
        {1'b0,1'b1,4'd4, 1'b1,2'd0},
        {1'b0,1'b1,4'd5, 1'b1,2'd0},
        {1'b0,1'b1,4'd6, 1'b1,2'd0},
        {1'b0,1'b1,4'd1, 1'b0,2'd0},
        {1'b0,1'b0,4'd4, 1'b0,2'd0},
        {1'b1,1'b0,4'd7, 1'b0,2'd0},
        {1'b1,1'b1,4'd7, 1'b0,2'd0},
        {1'b0,1'b0,4'd2, 1'b0,2'd0},
        {1'b1,1'b1,4'd5, 1'b1,2'd0}
    };

    logic clk = 0, rst = 1;
    logic insn_valid = 0, irq_pending = 0;
    logic [3:0] insn_class = 0;
    logic [63:0] msr_in = 0;
    logic insn_done, trace_taken, irq_taken, redirect_valid, msr_wr;
    logic [63:0] redirect_addr, status_word, msr_new;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    trc_unit i_trc_unit (.clk, .rst, .insn_valid, .insn_class, .msr_in, .irq_pending,
        .insn_done, .trace_taken, .irq_taken, .redirect_valid, .redirect_addr,
        .status_word, .msr_wr, .msr_new);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] mk_msr(input logic step, input logic brtr);
        logic [63:0] m = '0;
        m[63-53] = step;
        m[63-54] = brtr;
        return m;
    endfunction

    function automatic logic [63:0] exp_status(input logic [1:0] kind);
        logic [63:0] s = '0;
        s[63-33] = 1'b1;
        if (kind == 2'd1) s[63-35] = 1'b1;
        if (kind == 2'd2) s[63-36] = 1'b1;
        return s;
    endfunction

    function automatic logic [63:0] exp_entry(input logic [63:0] m);
        logic [63:0] r = m;
        int clr [7] = '{48, 49, 53, 54, 58, 59, 62};
        foreach (clr[i]) r[63-clr[i]] = 1'b0;
        r[63] = 1'b1;
        r[0]  = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // drive on falling edge, sample 1 time unit later, then finish the cycle
    task automatic drive(input logic v, input logic [3:0] c, input logic [63:0] m, input logic irq);
        @(negedge clk);
        insn_valid = v; insn_class = c; msr_in = m; irq_pending = irq;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] ones;
        ones = '1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        drive(1, 4'd1, '0, 0);
        chk("R1 done", insn_done, 1);
        chk("R1 no trace", trace_taken, 0);
        chk("R1 no save", msr_wr, 0);

        // table walk: R2 R3 R4 R7
        for (int i = 0; i < NVEC; i++) begin
            logic [8:0] e;
            e = VEC[i];
            drive(1, e[6:3], mk_msr(e[8], e[7]), 0);
            chk("R2 arming insn completes", insn_done, 1);
            drive(1, 4'd1, '0, 0);
            chk(e[6:3] == 4'd7 ? "R4 rfi trace" : "R3 trace taken", trace_taken, e[2]);
            if (e[2]) begin
                chk("R2 redirect", redirect_addr, 64'hD00);
                chk("R2 dropped", insn_done, 0);
                chk("R7 status", status_word, exp_status(e[1:0]));
                drive(0, 4'd0, ones, 0);
                chk("R8 msr_wr", msr_wr, 1);
                chk("R8 msr_new", msr_new, exp_entry(ones));
            end else begin
                drive(0, 4'd0, '0, 0);
            end
        end

        // R5: pending survives idle cycles
        drive(1, 4'd3, mk_msr(1, 0), 0);
        repeat (3) drive(0, 4'd0, '0, 0);
        drive(1, 4'd1, '0, 0);
        chk("R5 held trace", trace_taken, 1);
        chk("R5 status", status_word, exp_status(2));
        drive(0, 4'd0, '0, 0);

        // R6: trace beats interrupt
        drive(1, 4'd2, mk_msr(1, 0), 0);
        drive(1, 4'd1, '0, 1);
        chk("R6 trace", trace_taken, 1);
        chk("R6 no irq", irq_taken, 0);
        // R8: save cycle ignores an instruction with step set
        drive(1, 4'd1, mk_msr(1, 1), 0);
        chk("R8 save", msr_wr, 1);
        chk("R8 ignored", insn_done, 0);
        chk("R8 entry value", msr_new, exp_entry(mk_msr(1, 1)));
        drive(1, 4'd1, '0, 0);
        chk("R8 no arm from ignored", trace_taken, 0);
        chk("R8 completes", insn_done, 1);

        // R9: interrupt with no pending trace
        drive(1, 4'd1, '0, 1);
        chk("R9 irq", irq_taken, 1);
        chk("R9 not done", insn_done, 0);
        chk("R9 no redirect", redirect_valid, 0);
        drive(0, 4'd0, '0, 0);
        chk("R9 save", msr_wr, 1);
        drive(0, 4'd0, '0, 0);

        // R1: reset drops a pending trace
        drive(1, 4'd1, mk_msr(1, 0), 0);
        @(negedge clk); rst = 1; insn_valid = 0;
        @(negedge clk); rst = 0;
        drive(1, 4'd1, '0, 0);
        chk("R1 reset clears pending", trace_taken, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule